// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block gathers the interrupt flags of three timer/counters into one eight-bit flag register and pairs it with an eight-bit enable register. Single-cycle event pulses from the timers (compare matches, overflows, an input capture) set their flags. Software clears a flag by writing a one to it. The interrupt sequencer clears a flag by acknowledging that source's vector.

A request leaves the block for a source only when three things hold: the global interrupt enable is high, the source's enable bit is set, and its flag is set. A fixed-priority encoder turns the pending requests into one vector number. The timer2 overflow flag has a second origin. While the timer2 up/down PWM mode input is high, the flag follows a turnaround-at-zero pulse instead of the wraparound pulse.

Top module: `tmr_irq_flag_ctrl`

## Requirements
- R1: After reset the flag register, the enable register, `irq_req` and `irq_any` are all zero.
- R2: An event pulse on `evt_in[b]` sets flag bit b at the next clock edge. The bit positions are: 7 timer2 compare, 6 timer2 overflow, 5 timer1 capture, 4 timer1 compare A, 3 timer1 compare B, 2 timer1 overflow, 1 timer0 compare, 0 timer0 overflow.
- R3: A write with `bus_sel`=0 clears every flag whose `bus_wdata` bit is one. Flags whose `bus_wdata` bit is zero keep their value.
- R4: A pulse on `ack_valid` with vector index v clears flag bit 7-v only, so vector 0 is timer2 compare and vector 7 is timer0 overflow.
- R5: `irq_req[b]` is one exactly when `global_ie`, enable bit b and flag bit b are all one.
- R6: With `t2_pwm_mode`=1, flag bit 6 is set by `t2_turn_evt` and `evt_in[6]` is ignored. With `t2_pwm_mode`=0, `evt_in[6]` sets the flag and `t2_turn_evt` is ignored.
- R7: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_any` is high when any request is pending. `irq_vec` then gives the lowest vector index among the pending requests, which is the highest pending flag bit b, reported as 7-b.
- R9: A write with `bus_sel`=1 loads the enable register at the clock edge. A flag that is already pending raises its request in the next cycle.
- R10: `bus_rdata` shows the flag register when `bus_sel`=0 and the enable register when `bus_sel`=1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | Single-cycle event pulses, one per flag bit |
| t2_turn_evt | input | 1 | Timer2 direction change at zero pulse |
| t2_pwm_mode | input | 1 | Timer2 up/down PWM mode selects turnaround as overflow |
| global_ie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 flags, 1 enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| ack_valid | input | 1 | Vector acknowledge pulse |
| ack_idx | input | 3 | Vector index being acknowledged |
| irq_req | output | 8 | Per-source interrupt request |
| irq_any | output | 1 | Any request pending |
| irq_vec | output | 3 | Highest-priority pending vector index |

## Verification
The assertions assume the following about the inputs:
- `ack_idx` always names one of the eight sources.
- Writes and acknowledges can arrive in any combination with events in the same cycle.
- Reset is asserted long enough that no event is in flight when it is released.

The stimulus keeps inside these limits as follows. It draws `ack_idx` from the full three-bit range. It holds every input idle while reset is low. It overlaps random events, write-one masks and acknowledges freely, so that set-versus-clear collisions occur often.

// File: rtl/tifc_pkg.sv
package tifc_pkg;

  localparam int unsigned TIFC_SRC_N = 8;
  localparam int unsigned TIFC_T2_OVF_BIT = 6;

  // vector index of a flag bit: top bit is vector 0
  function automatic int unsigned bit_to_vec(input int unsigned b, input int unsigned n);
    return n - 1 - b;
  endfunction

  // flag bit addressed by a vector index
  function automatic int unsigned vec_to_bit(input int unsigned v, input int unsigned n);
    return n - 1 - v;
  endfunction

  // next flag state: set has priority over clear
  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tifc_event_sel.sv
module tifc_event_sel #(
  parameter int unsigned N_SRC   = tifc_pkg::TIFC_SRC_N,
  parameter int unsigned OVF_BIT = tifc_pkg::TIFC_T2_OVF_BIT
) (
  input  logic [N_SRC-1:0] evt_in,
  input  logic             turn_evt,
  input  logic             pwm_mode,
  output logic [N_SRC-1:0] evt_eff
);

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_sel
      if (g == OVF_BIT) begin : g_ovf
        assign evt_eff[g] = pwm_mode ? turn_evt : evt_in[g];
      end else begin : g_plain
        assign evt_eff[g] = evt_in[g];
      end
    end
  endgenerate

endmodule

// File: rtl/tifc_flag_reg.sv
module tifc_flag_reg #(
  parameter int unsigned N_SRC = tifc_pkg::TIFC_SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] flag_q
);

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[g] <= 1'b0;
        else        flag_q[g] <= tifc_pkg::next_flag(flag_q[g], set_vec[g], clr_vec[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/tifc_prio_enc.sv
module tifc_prio_enc #(
  parameter int unsigned N_SRC = tifc_pkg::TIFC_SRC_N,
  localparam int unsigned VW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [VW-1:0]    vec
);

  // scan upward; the last hit (highest bit, lowest vector) wins
  always_comb begin
    any = 1'b0;
    vec = '0;
    for (int unsigned b = 0; b < N_SRC; b++) begin
      if (req[b]) begin
        any = 1'b1;
        vec = VW'(tifc_pkg::bit_to_vec(b, N_SRC));
      end
    end
  end

endmodule

// File: rtl/tmr_irq_flag_ctrl.sv
module tmr_irq_flag_ctrl #(
  parameter int unsigned N_SRC   = tifc_pkg::TIFC_SRC_N,
  parameter int unsigned OVF_BIT = tifc_pkg::TIFC_T2_OVF_BIT,
  localparam int unsigned VW     = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_in,
  input  logic             t2_turn_evt,
  input  logic             t2_pwm_mode,
  input  logic             global_ie,
  input  logic             bus_we,
  input  logic             bus_sel,
  input  logic [N_SRC-1:0] bus_wdata,
  output logic [N_SRC-1:0] bus_rdata,
  input  logic             ack_valid,
  input  logic [VW-1:0]    ack_idx,
  output logic [N_SRC-1:0] irq_req,
  output logic             irq_any,
  output logic [VW-1:0]    irq_vec
);

  localparam logic [N_SRC-1:0] ONE = {{(N_SRC-1){1'b0}}, 1'b1};

  logic [N_SRC-1:0] evt_eff;
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] wr_clr;
  logic [N_SRC-1:0] ack_clr;
  logic [N_SRC-1:0] flag_clr;
  logic             en_wr;

  tifc_event_sel #(.N_SRC(N_SRC), .OVF_BIT(OVF_BIT)) u_evsel (
    .evt_in  (evt_in),
    .turn_evt(t2_turn_evt),
    .pwm_mode(t2_pwm_mode),
    .evt_eff (evt_eff)
  );

  assign wr_clr   = (bus_we && !bus_sel) ? bus_wdata : '0;
  assign ack_clr  = ack_valid ? (ONE << tifc_pkg::vec_to_bit(32'(ack_idx), N_SRC)) : '0;
  assign flag_clr = wr_clr | ack_clr;

  tifc_flag_reg #(.N_SRC(N_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(evt_eff),
    .clr_vec(flag_clr),
    .flag_q (flag_q)
  );

  assign en_wr = bus_we && bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= bus_wdata;
  end

  assign bus_rdata = bus_sel ? en_q : flag_q;
  assign irq_req   = global_ie ? (flag_q & en_q) : '0;

  tifc_prio_enc #(.N_SRC(N_SRC)) u_prio (
    .req(irq_req),
    .any(irq_any),
    .vec(irq_vec)
  );

endmodule

// File: rtl/tifc_checker.sv
module tifc_checker #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned VW   = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_eff,
  input logic [N_SRC-1:0] flag_q,
  input logic [N_SRC-1:0] en_q,
  input logic             global_ie,
  input logic             bus_we,
  input logic             bus_sel,
  input logic [N_SRC-1:0] bus_wdata,
  input logic             ack_valid,
  input logic [VW-1:0]    ack_idx,
  input logic [N_SRC-1:0] irq_req,
  input logic             irq_any,
  input logic [VW-1:0]    irq_vec
);

  localparam logic [N_SRC-1:0] ONE = {{(N_SRC-1){1'b0}}, 1'b1};

  logic [N_SRC-1:0] ack_bit;
  logic [N_SRC-1:0] vec_bit;
  assign ack_bit = ONE << (N_SRC - 1 - 32'(ack_idx));
  assign vec_bit = ONE << (N_SRC - 1 - 32'(irq_vec));

  // R2 / R7: an effective event always leaves its flag set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(evt_eff)) == $past(evt_eff)));

  // R2: no flag rises without an event
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_eff)) == '0));

  a_r3_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel) |=> ((flag_q & $past(bus_wdata & ~evt_eff)) == '0));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ((flag_q & $past(ack_bit & ~evt_eff)) == '0));

  a_r5_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !global_ie |-> (irq_req == '0));

  a_r5_req_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~(flag_q & en_q)) == '0));

  a_r8_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_req != '0));

  a_r8_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((irq_req & vec_bit) != '0));

  a_r8_vec_highest: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((irq_req >> (N_SRC - 32'(irq_vec))) == '0));

  a_r9_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel) |=> (en_q == $past(bus_wdata)));

endmodule

bind tmr_irq_flag_ctrl tifc_checker #(.N_SRC(N_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_eff  (evt_eff),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .global_ie(global_ie),
  .bus_we   (bus_we),
  .bus_sel  (bus_sel),
  .bus_wdata(bus_wdata),
  .ack_valid(ack_valid),
  .ack_idx  (ack_idx),
  .irq_req  (irq_req),
  .irq_any  (irq_any),
  .irq_vec  (irq_vec)
);

// File: tb/tmr_irq_flag_ctrl_test.sv
module tmr_irq_flag_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_in = '0;
  logic       t2_turn_evt = 1'b0;
  logic       t2_pwm_mode = 1'b0;
  logic       global_ie = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [7:0] irq_req;
  logic       irq_any;
  logic [2:0] irq_vec;

  logic [7:0] m_flags = '0;
  logic [7:0] m_en = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .t2_turn_evt(t2_turn_evt),
    .t2_pwm_mode(t2_pwm_mode), .global_ie(global_ie), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_req(irq_req),
    .irq_any(irq_any), .irq_vec(irq_vec)
  );

  function automatic logic [7:0] exp_req(input logic [7:0] f, input logic [7:0] e, input logic g);
    return g ? (f & e) : 8'h00;
  endfunction

  // lowest vector index pending; vector v lives in flag bit 7-v
  function automatic logic [2:0] exp_vec(input logic [7:0] r);
    for (int v = 7; v >= 0; v--) if (r[7 - v]) exp_vec = 3'(v);
    if (r == 8'h00) exp_vec = 3'd0;
  endfunction

  function automatic logic [7:0] exp_next(input logic [7:0] f);
    logic [7:0] set, clr;
    set = evt_in;
    set[6] = t2_pwm_mode ? t2_turn_evt : evt_in[6];
    clr = 8'h00;
    if (bus_we && !bus_sel) clr = bus_wdata;
    if (ack_valid) clr[7 - ack_idx] = 1'b1;
    return (f & ~clr) | set;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // outputs are compared 1 time unit after the negedge drive, model advanced at posedge
  task automatic tick(input string tag);
    logic [7:0] r;
    #1;
    r = exp_req(m_flags, m_en, global_ie);
    cmp(tag, "irq_req", int'(irq_req), int'(r));
    cmp(tag, "irq_any", int'(irq_any), int'(r != 8'h00));
    if (r != 8'h00) cmp(tag, "irq_vec", int'(irq_vec), int'(exp_vec(r)));
    cmp(tag, "bus_rdata", int'(bus_rdata), int'(bus_sel ? m_en : m_flags));
    @(posedge clk);
    m_flags = exp_next(m_flags);
    if (bus_we && bus_sel) m_en = bus_wdata;
    @(negedge clk);
  endtask

  task automatic idle();
    evt_in = '0; t2_turn_evt = 0; bus_we = 0; ack_valid = 0; bus_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    cmp("R1", "irq_any", int'(irq_any), 0);
    cmp("R1", "flags", int'(bus_rdata), 0);
    bus_sel = 1; #1;
    cmp("R1", "enables", int'(bus_rdata), 0);
    rst_n = 1;
    @(negedge clk);
    tick("R1");

    // R9 / R10: load enables and read them back
    bus_we = 1; bus_sel = 1; bus_wdata = 8'hFF; tick("R9");
    idle(); tick("R10");
    bus_sel = 0; global_ie = 1;
    // R2: distinct bit pattern
    evt_in = 8'b1010_0101; tick("R2");
    idle(); tick("R2");
    evt_in = 8'b0101_1010; tick("R2");
    idle(); tick("R5");
    // R3: write-one clears bits 0 and 2 only
    bus_we = 1; bus_wdata = 8'h05; tick("R3");
    idle(); tick("R3");
    // R7: set and write-clear collide on bit 7
    evt_in = 8'h80; bus_we = 1; bus_wdata = 8'h80; tick("R7");
    idle(); tick("R7");
    // R7: set and acknowledge collide on bit 1
    evt_in = 8'h02; ack_valid = 1; ack_idx = 3'd6; tick("R7");
    idle(); tick("R7");
    // R4: acknowledges clear single flags
    ack_valid = 1; ack_idx = 3'd0; tick("R4");
    idle(); tick("R4");
    ack_valid = 1; ack_idx = 3'd7; tick("R4");
    idle(); tick("R8");
    // R6: turnaround vs wraparound on bit 6
    bus_we = 1; bus_wdata = 8'hFF; tick("R6");
    idle(); t2_pwm_mode = 1; evt_in[6] = 1; tick("R6");
    idle(); tick("R6");
    t2_turn_evt = 1; tick("R6");
    idle(); t2_pwm_mode = 0; bus_we = 1; bus_wdata = 8'h40; tick("R6");
    idle(); t2_turn_evt = 1; tick("R6");
    idle(); tick("R6");
    // R9: enable after pending flag raises request next cycle
    bus_sel = 1; bus_we = 1; bus_wdata = 8'h00; tick("R9");
    idle(); bus_sel = 0; evt_in = 8'h11; tick("R9");
    idle(); bus_sel = 1; bus_we = 1; bus_wdata = 8'h10; tick("R9");
    idle(); tick("R9");
    // R5: global enable low masks everything
    global_ie = 0; tick("R5");

    for (int i = 0; i < 4000; i++) begin
      evt_in      = 8'($urandom) & 8'($urandom) & 8'($urandom);
      t2_turn_evt = ($urandom % 5) == 0;
      if (($urandom % 50) == 0) t2_pwm_mode = ~t2_pwm_mode;
      global_ie   = ($urandom % 6) != 0;
      bus_we      = ($urandom % 4) == 0;
      bus_sel     = ($urandom % 3) == 0;
      bus_wdata   = 8'($urandom);
      ack_valid   = ($urandom % 5) == 0;
      ack_idx     = 3'($urandom);
      tick("R8 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule